// File: doc/BRIEF.md
# Indexed Flash Block Protection Registers

This block keeps access-control state for the flash devices behind two external chip selects. Each chip select's address window is split into 16 equal blocks, and every block carries three flags: a lock, a write-protect and a read-protect. Software does not reach these flags directly. Each chip select has a single byte-wide register. A pointer field in that byte picks the block, and the low bits of the same byte carry that block's flags.

A host register port writes and reads the two registers, at select values 0 and 1. A second, privileged management port can set or clear the lock of any block, even when the host cannot. Host locking is one-way: once a block is locked from the host side, the host can no longer change its flags. An unlock pulse clears the locks. So does a standby-domain reset, when a configuration input allows it.

For every flash access the block finds the target block number from the address and a programmable block size. It then raises combinational inhibit flags for reads or writes that the stored flags forbid.

Top module: `flash_prot_regs`

## Requirements
- R1: After `rst`, every block of both chip selects has lock 0, write-protect 1 and read-protect 0, and both pointers are 0. A read of either register then returns 0x02.
- R2: A register read returns the byte {pointer[3:0], 0, lock, write-protect, read-protect} of the block the pointer selects, on `h_rdata` one cycle after `h_rd`. Bit 3 always reads 0.
- R3: A host write with bit 3 = 0 stores bits 7-4 as the pointer. If the newly selected block is unlocked, the write also stores bits 2, 1 and 0 into that block's lock, write-protect and read-protect flags.
- R4: A host write with bit 3 = 1 only moves the pointer and changes no flag.
- R5: While a block's lock is 1, host writes leave its three flags unchanged. The pointer still moves.
- R6: A management write with `m_lock`=1 sets the chosen block's lock and keeps its other two flags. With `m_lock`=0 it clears the lock, sets write-protect to 1 and clears read-protect.
- R7: An `unlock` pulse clears every lock in both chip selects. Each block that was locked becomes write-protected and read-allowed. Unlocked blocks keep their flags, and all other flag writes in that cycle are dropped.
- R8: `sb_rst` acts like `unlock` when `sb_clr_en` is 1, and has no effect when `sb_clr_en` is 0.
- R9: The two chip selects hold separate pointers and flags. A register write for one never alters the other.
- R10: The accessed block number is `acc_addr[14+s+3 : 14+s]`, where s is `acc_size` (0 = 16 KB up to 6 = 1 MB). Codes 7 are treated as 6, and higher address bits are ignored.
- R11: `wr_inhibit` = `acc_wr` AND write-protect of the accessed block. `rd_inhibit` = `acc_rd` AND read-protect of that block. Both follow the inputs in the same cycle.
- R12: If a management write and a host data write target the same block in one cycle, the management write alone takes effect on that block's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high main reset |
| sb_rst | input | 1 | Standby-domain reset pulse |
| sb_clr_en | input | 1 | Lets `sb_rst` clear locks |
| unlock | input | 1 | One-cycle unlock command |
| h_wr | input | 1 | Host register write strobe |
| h_rd | input | 1 | Host register read strobe |
| h_sel | input | 1 | Register (chip select) chosen by the host |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Registered read byte |
| m_wr | input | 1 | Management write strobe |
| m_sel | input | 1 | Chip select for management write |
| m_blk | input | 4 | Block number for management write |
| m_lock | input | 1 | Lock value for management write |
| acc_cs | input | 1 | Chip select of the flash access |
| acc_addr | input | 24 | Address within the chip select window |
| acc_size | input | 3 | Block size code |
| acc_wr | input | 1 | Flash write in progress |
| acc_rd | input | 1 | Flash read in progress |
| wr_inhibit | output | 1 | Block the flash write |
| rd_inhibit | output | 1 | Block the flash read |

## Verification
Several properties are checked on every cycle. A locked block's flags stay put under host traffic. A management clear or an unlock always leaves the block write-protected and read-allowed. An index-only write never moves a flag, reset restores the defaults, and the inhibit flags never rise without the matching access strobe. Other behaviour depends on concrete values, so only the bench scenarios show it. These are the read byte layout, the address-to-block mapping for each size code including the clamp and the wrap, the separation of the two chip selects, the priority of management writes in the same cycle, and the enable gating of the standby reset.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  localparam int REG_W      = 8;
  localparam int PTR_LSB    = 4;
  localparam int IDX_ONLY_B = 3;
  localparam int LOCK_B     = 2;
  localparam int WP_B       = 1;
  localparam int RP_B       = 0;
  localparam int SZW        = 3;

  typedef enum logic [SZW-1:0] {
    SZ_16K  = 3'd0,
    SZ_32K  = 3'd1,
    SZ_64K  = 3'd2,
    SZ_128K = 3'd3,
    SZ_256K = 3'd4,
    SZ_512K = 3'd5,
    SZ_1M   = 3'd6
  } blk_size_e;
endpackage

// File: rtl/fpr_blkdec.sv
module fpr_blkdec
  import flash_prot_pkg::*;
#(
  parameter int AW        = 24,
  parameter int NBLK      = 16,
  parameter int MIN_SHIFT = 14
) (
  input  logic [AW-1:0]            addr,
  input  logic [SZW-1:0]           size,
  output logic [$clog2(NBLK)-1:0]  blk
);
  localparam int IDXW = $clog2(NBLK);

  logic [SZW-1:0] eff;
  logic [AW-1:0]  shifted;
  int             shamt;

  always_comb begin
    // sizes above the largest code behave as the largest
    eff     = (size > SZ_1M) ? SZ_1M : size;
    shamt   = MIN_SHIFT + int'(eff);
    shifted = addr >> shamt;
    blk     = shifted[IDXW-1:0];
  end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import flash_prot_pkg::*;
#(
  parameter int NBLK = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_all,
  input  logic                     hw_en,
  input  logic [REG_W-1:0]         hw_data,
  input  logic                     mw_en,
  input  logic [$clog2(NBLK)-1:0]  mw_blk,
  input  logic                     mw_lock,
  input  logic [$clog2(NBLK)-1:0]  look_blk,
  output logic [REG_W-1:0]         rd_byte,
  output logic                     look_wp,
  output logic                     look_rp
);
  localparam int IDXW = $clog2(NBLK);

  logic [IDXW-1:0] idx_q;
  logic [NBLK-1:0] lock_q, wp_q, rp_q;
  logic [IDXW-1:0] new_idx;
  logic            data_wr;

  assign new_idx = hw_data[PTR_LSB +: IDXW];
  assign data_wr = hw_en && !hw_data[IDX_ONLY_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      lock_q <= '0;
      wp_q   <= '1;
      rp_q   <= '0;
    end else begin
      if (hw_en) idx_q <= new_idx;
      for (int b = 0; b < NBLK; b++) begin
        if (clr_all) begin
          if (lock_q[b]) begin
            lock_q[b] <= 1'b0;
            wp_q[b]   <= 1'b1;
            rp_q[b]   <= 1'b0;
          end
        end else if (mw_en && mw_blk == IDXW'(b)) begin
          if (mw_lock) begin
            lock_q[b] <= 1'b1;
          end else begin
            lock_q[b] <= 1'b0;
            wp_q[b]   <= 1'b1;
            rp_q[b]   <= 1'b0;
          end
        end else if (data_wr && new_idx == IDXW'(b) && !lock_q[b]) begin
          lock_q[b] <= hw_data[LOCK_B];
          wp_q[b]   <= hw_data[WP_B];
          rp_q[b]   <= hw_data[RP_B];
        end
      end
    end
  end

  assign rd_byte = {idx_q, 1'b0, lock_q[idx_q], wp_q[idx_q], rp_q[idx_q]};
  assign look_wp = wp_q[look_blk];
  assign look_rp = rp_q[look_blk];

  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    rst |=> (idx_q == '0 && lock_q == '0 && wp_q == '1 && rp_q == '0));

  // R4
  index_only_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_en && hw_data[IDX_ONLY_B] && !mw_en && !clr_all)
      |=> ($stable(lock_q) && $stable(wp_q) && $stable(rp_q)));

  // R7
  unlock_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (lock_q == '0));

  for (genvar g = 0; g < NBLK; g++) begin : g_blk_chk
    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (lock_q[g] && !clr_all && !(mw_en && mw_blk == IDXW'(g)))
        |=> (lock_q[g] && $stable(wp_q[g]) && $stable(rp_q[g])));
    // R6
    mgmt_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (mw_en && mw_blk == IDXW'(g) && !mw_lock && !clr_all)
        |=> (!lock_q[g] && wp_q[g] && !rp_q[g]));
    // R6
    mgmt_set_chk: assert property (@(posedge clk) disable iff (rst)
      (mw_en && mw_blk == IDXW'(g) && mw_lock && !clr_all)
        |=> (lock_q[g] && $stable(wp_q[g]) && $stable(rp_q[g])));
  end
endmodule

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
  import flash_prot_pkg::*;
#(
  parameter int NCS       = 2,
  parameter int NBLK      = 16,
  parameter int AW        = 24,
  parameter int MIN_SHIFT = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sb_rst,
  input  logic                      sb_clr_en,
  input  logic                      unlock,
  input  logic                      h_wr,
  input  logic                      h_rd,
  input  logic [$clog2(NCS)-1:0]    h_sel,
  input  logic [REG_W-1:0]          h_wdata,
  output logic [REG_W-1:0]          h_rdata,
  input  logic                      m_wr,
  input  logic [$clog2(NCS)-1:0]    m_sel,
  input  logic [$clog2(NBLK)-1:0]   m_blk,
  input  logic                      m_lock,
  input  logic [$clog2(NCS)-1:0]    acc_cs,
  input  logic [AW-1:0]             acc_addr,
  input  logic [SZW-1:0]            acc_size,
  input  logic                      acc_wr,
  input  logic                      acc_rd,
  output logic                      wr_inhibit,
  output logic                      rd_inhibit
);
  localparam int CSW  = $clog2(NCS);
  localparam int IDXW = $clog2(NBLK);

  logic             clr_all;
  logic [IDXW-1:0]  acc_blk;
  logic [REG_W-1:0] bank_byte [NCS];
  logic [NCS-1:0]   bank_wp, bank_rp;

  assign clr_all = unlock || (sb_rst && sb_clr_en);

  fpr_blkdec #(
    .AW(AW), .NBLK(NBLK), .MIN_SHIFT(MIN_SHIFT)
  ) i_blkdec (
    .addr(acc_addr),
    .size(acc_size),
    .blk (acc_blk)
  );

  for (genvar c = 0; c < NCS; c++) begin : g_bank
    fpr_bank #(.NBLK(NBLK)) i_bank (
      .clk     (clk),
      .rst     (rst),
      .clr_all (clr_all),
      .hw_en   (h_wr && h_sel == CSW'(c)),
      .hw_data (h_wdata),
      .mw_en   (m_wr && m_sel == CSW'(c)),
      .mw_blk  (m_blk),
      .mw_lock (m_lock),
      .look_blk(acc_blk),
      .rd_byte (bank_byte[c]),
      .look_wp (bank_wp[c]),
      .look_rp (bank_rp[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       h_rdata <= '0;
    else if (h_rd) h_rdata <= bank_byte[h_sel];
  end

  assign wr_inhibit = acc_wr && bank_wp[acc_cs];
  assign rd_inhibit = acc_rd && bank_rp[acc_cs];

  // R2
  rd_bit3_zero_chk: assert property (@(posedge clk) disable iff (rst)
    h_rd |=> !h_rdata[IDX_ONLY_B]);

  // R11
  wr_inh_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_inhibit |-> acc_wr);

  // R11
  rd_inh_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd_inhibit |-> acc_rd);
endmodule

// File: tb/test_flash_prot_regs.sv
module test_flash_prot_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sb_rst = 1'b0, sb_clr_en = 1'b0, unlock = 1'b0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [0:0]  h_sel = '0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        m_wr = 1'b0, m_lock = 1'b0;
  logic [0:0]  m_sel = '0;
  logic [3:0]  m_blk = '0;
  logic [0:0]  acc_cs = '0;
  logic [23:0] acc_addr = '0;
  logic [2:0]  acc_size = '0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic        wr_inhibit, rd_inhibit;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  flash_prot_regs i_flash_prot_regs (
    .clk(clk), .rst(rst), .sb_rst(sb_rst), .sb_clr_en(sb_clr_en),
    .unlock(unlock), .h_wr(h_wr), .h_rd(h_rd), .h_sel(h_sel),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .m_wr(m_wr), .m_sel(m_sel),
    .m_blk(m_blk), .m_lock(m_lock), .acc_cs(acc_cs), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .wr_inhibit(wr_inhibit), .rd_inhibit(rd_inhibit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_sel = s; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic host_rd(input logic s, input logic [7:0] exp, input string req);
    @(negedge clk);
    h_rd = 1'b1; h_sel = s;
    @(negedge clk);
    h_rd = 1'b0;
    chk(req, h_rdata, exp);
  endtask

  task automatic mgmt_wr(input logic s, input logic [3:0] b, input logic l);
    @(negedge clk);
    m_wr = 1'b1; m_sel = s; m_blk = b; m_lock = l;
    @(negedge clk);
    m_wr = 1'b0;
  endtask

  task automatic access(input logic cs, input logic [23:0] a, input logic [2:0] sz,
                        input logic w, input logic r, input logic ew, input logic er,
                        input string req);
    @(negedge clk);
    acc_cs = cs; acc_addr = a; acc_size = sz; acc_wr = w; acc_rd = r;
    #1;
    chk(req, {7'd0, wr_inhibit}, {7'd0, ew});
    chk(req, {7'd0, rd_inhibit}, {7'd0, er});
    acc_wr = 1'b0; acc_rd = 1'b0;
  endtask

  // entry: {is_read, sel, write byte, expected read byte, requirement number}
  localparam int NVEC = 16;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h30, 8'h00, 4'd3},   // R3: block 3 opened for writes
    {1'b1, 1'b0, 8'h00, 8'h30, 4'd3},
    {1'b0, 1'b0, 8'h58, 8'h00, 4'd4},   // R4: pointer-only move to 5
    {1'b1, 1'b0, 8'h00, 8'h52, 4'd4},
    {1'b0, 1'b0, 8'h3B, 8'h00, 4'd4},   // R4: back to 3, bits ignored
    {1'b1, 1'b0, 8'h00, 8'h30, 4'd4},
    {1'b0, 1'b1, 8'h71, 8'h00, 4'd9},   // R9: second chip select
    {1'b1, 1'b1, 8'h00, 8'h71, 4'd9},
    {1'b1, 1'b0, 8'h00, 8'h30, 4'd9},
    {1'b0, 1'b0, 8'h36, 8'h00, 4'd5},   // R5: lock block 3
    {1'b1, 1'b0, 8'h00, 8'h36, 4'd5},
    {1'b0, 1'b0, 8'h31, 8'h00, 4'd5},   // R5: attempt ignored
    {1'b1, 1'b0, 8'h00, 8'h36, 4'd5},
    {1'b0, 1'b0, 8'hA7, 8'h00, 4'd2},   // R2: all three bits set at 10
    {1'b1, 1'b0, 8'h00, 8'hA7, 4'd2},
    {1'b1, 1'b1, 8'h00, 8'h71, 4'd9}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: defaults
    host_rd(1'b0, 8'h02, "R1");
    host_rd(1'b1, 8'h02, "R1");
    access(1'b0, 24'h0F0000, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R1");

    foreach (VEC[i]) begin
      if (VEC[i][21]) host_rd(VEC[i][20], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
      else            host_wr(VEC[i][20], VEC[i][19:12]);
    end

    // R10 / R11: cs1 block 7 has wp0 rd1, other cs1 blocks default
    access(1'b1, 24'h01C000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    access(1'b1, 24'h01C000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
    access(1'b1, 24'h05C000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    access(1'b1, 24'h070000, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    access(1'b1, 24'h060000, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
    access(1'b1, 24'h700000, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    access(1'b0, 24'hA00000, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
    access(1'b0, 24'hA00000, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, "R11");

    // R6: management override on locked block 10
    host_wr(1'b0, 8'hA8);
    mgmt_wr(1'b0, 4'd10, 1'b0);
    host_rd(1'b0, 8'hA2, "R6");
    mgmt_wr(1'b0, 4'd10, 1'b1);
    host_rd(1'b0, 8'hA6, "R6");
    host_wr(1'b0, 8'hA0);
    host_rd(1'b0, 8'hA6, "R5");

    // R12: same-cycle host data write and management lock of block 5
    @(negedge clk);
    h_wr = 1'b1; h_sel = 1'b0; h_wdata = 8'h51;
    m_wr = 1'b1; m_sel = 1'b0; m_blk = 4'd5; m_lock = 1'b1;
    @(negedge clk);
    h_wr = 1'b0; m_wr = 1'b0;
    host_rd(1'b0, 8'h56, "R12");

    // R7: unlock pulse
    host_wr(1'b1, 8'h75);
    host_rd(1'b1, 8'h75, "R7");
    host_wr(1'b0, 8'h11);
    @(negedge clk); unlock = 1'b1;
    @(negedge clk); unlock = 1'b0;
    host_rd(1'b0, 8'h11, "R7");
    host_rd(1'b1, 8'h72, "R7");
    host_wr(1'b0, 8'hA8);
    host_rd(1'b0, 8'hA2, "R7");

    // R8: standby reset gated by enable
    host_wr(1'b0, 8'h15);
    host_rd(1'b0, 8'h15, "R8");
    @(negedge clk); sb_rst = 1'b1; sb_clr_en = 1'b0;
    @(negedge clk); sb_rst = 1'b0;
    host_rd(1'b0, 8'h15, "R8");
    @(negedge clk); sb_rst = 1'b1; sb_clr_en = 1'b1;
    @(negedge clk); sb_rst = 1'b0; sb_clr_en = 1'b0;
    host_rd(1'b0, 8'h12, "R8");

    // R1: reset in mid-run
    host_wr(1'b1, 8'h70);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    host_rd(1'b0, 8'h02, "R1");
    host_rd(1'b1, 8'h02, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule